// File: doc/BRIEF.md
# Transmit Cell Header-Check Inserter with Idle Fill

This block sits on the transmit path, between a cell source and a byte-serial line stage that has to receive a byte on every clock. The source delivers 53-byte cells, one byte per transfer. Byte 0 of each cell carries a start marker. Byte 4 of each cell is only a placeholder. As the first four header bytes pass through, the block accumulates a CRC-8 over them. It then writes the result into byte 4 in place of whatever the source sent there. The rest of the cell is forwarded unchanged.

The output always runs in fixed 53-byte slots. A new slot begins on the clock that follows the last byte of the previous slot. At the start of each slot the block decides what to send. If the source offers a start-of-cell byte, the slot carries that user cell. Otherwise the slot carries an idle cell, so the output rate stays constant whatever the source does.

Back-pressure rules on the input side:
- `in_ready` is high on the first cycle of every slot and on every cycle of a slot that carries a user cell.
- `in_ready` is low for the rest of an idle slot.
- Once a user cell has started, the source must present one byte per clock. The slot position advances whether or not a byte is offered.

Top module: `cell_hec_tx`

## Requirements
- R1: While reset is held, `out_data` is 0x00, `out_sop` is 0, `out_idle` is 0 and `in_ready` is 1. The first slot is decided on the first rising edge after reset is released.
- R2: Every output byte belongs to a 53-byte slot, and slots follow each other with no gap. `out_sop` is 1 exactly on byte 0 of each slot.
- R3: In every slot, output byte 4 holds the CRC-8 of output bytes 0 to 3. The CRC uses the polynomial x^8+x^2+x+1 (0x07) and an initial value of 0, taking each byte MSB first. This equals the remainder of the 32 header bits times x^8 divided by the polynomial. The byte the source supplied at position 4 is accepted and discarded.
- R4: When a slot starts without `in_valid` and `in_sop` both high, an idle cell is sent. Bytes 0 to 4 of an idle cell are all 0x00, since the check byte of an all-zero header is 0x00.
- R5: Bytes 5 to 52 of an idle cell are the fill value 0x6A. `out_idle` is 1 for all 53 bytes of an idle cell and 0 for all bytes of a user cell.
- R6: A user cell's bytes leave in input order, except at position 4. Each byte accepted on a rising edge appears on `out_data` right after that same edge.
- R7: `in_ready` is 1 on slot byte 0 and on bytes 1 to 52 of a user slot. It is 0 on bytes 1 to 52 of an idle slot.
- R8: A byte offered at the start of a slot without `in_sop` is consumed and dropped, and that slot carries an idle cell.
- R9: If `in_valid` is low at some position of a user cell, that output position carries 0x6A and the cell keeps its 53-byte length. When the gap falls in bytes 0 to 3, the 0x6A is part of the check-byte computation.
- R10: `in_sop` seen at positions 1 to 52 of a user cell is ignored, and the byte is forwarded as ordinary data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source offers a byte |
| in_sop | input | 1 | Offered byte is byte 0 of a cell |
| in_data | input | 8 | Offered byte |
| in_ready | output | 1 | Block takes the offered byte on this edge |
| out_data | output | 8 | Line byte, valid every clock after reset |
| out_sop | output | 1 | `out_data` is byte 0 of a slot |
| out_idle | output | 1 | Current slot is an idle cell |

## Verification
The bench builds the block with its default parameters: 53-byte cells, the check byte at position 4, fill value 0x6A and polynomial 0x07. With these values every slot is short enough to compare byte by byte against a model built from long division. The header sweep drives a one-hot header for each of the 32 bit positions, followed by pseudo-random headers. This exercises every CRC input bit on its own and in combination. Idle slots, stray bytes, input gaps in the header and in the payload, and a start marker placed inside a payload are all interleaved with back-to-back user cells.

// File: rtl/cell_tx_pkg.sv
package cell_tx_pkg;

  typedef enum logic {
    SRC_IDLE = 1'b0,
    SRC_USER = 1'b1
  } src_e;

  // One byte of a serial CRC-8, MSB first.
  function automatic logic [7:0] crc8_step(input logic [7:0] acc,
                                           input logic [7:0] din,
                                           input logic [7:0] poly);
    logic [7:0] r;
    r = acc ^ din;
    for (int i = 0; i < 8; i++) begin
      r = r[7] ? ((r << 1) ^ poly) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/cell_slot_ctr.sv
module cell_slot_ctr #(
  parameter int CELL_LEN = 53,
  parameter int PW       = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] pos,
  output logic          at_start
);
  localparam logic [PW-1:0] LAST = PW'(CELL_LEN - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0;
    end else if (pos == LAST) begin
      pos <= '0;
    end else begin
      pos <= pos + 1'b1;
    end
  end

  assign at_start = (pos == '0);
endmodule

// File: rtl/hec_acc.sv
module hec_acc
  import cell_tx_pkg::*;
#(
  parameter int         PW       = 6,
  parameter int         HEC_POS  = 4,
  parameter logic [7:0] CRC_POLY = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] pos,
  input  logic [7:0]    byte_in,
  output logic [7:0]    hec
);
  localparam logic [PW-1:0] HPOS = PW'(HEC_POS);

  logic [7:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q <= 8'h00;
    end else if (pos == '0) begin
      crc_q <= crc8_step(8'h00, byte_in, CRC_POLY);
    end else if (pos < HPOS) begin
      crc_q <= crc8_step(crc_q, byte_in, CRC_POLY);
    end
  end

  assign hec = crc_q;
endmodule

// File: rtl/cell_byte_sel.sv
module cell_byte_sel
  import cell_tx_pkg::*;
#(
  parameter int         PW        = 6,
  parameter int         HEC_POS   = 4,
  parameter logic [7:0] FILL_BYTE = 8'h6A
) (
  input  src_e          src,
  input  logic [PW-1:0] pos,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic [7:0]    hec,
  output logic [7:0]    nxt_byte
);
  localparam logic [PW-1:0] HPOS = PW'(HEC_POS);

  always_comb begin
    if (pos == HPOS) begin
      nxt_byte = hec;
    end else if (src == SRC_IDLE) begin
      nxt_byte = (pos < HPOS) ? 8'h00 : FILL_BYTE;
    end else begin
      nxt_byte = in_valid ? in_data : FILL_BYTE;
    end
  end
endmodule

// File: rtl/cell_hec_tx.sv
module cell_hec_tx
  import cell_tx_pkg::*;
#(
  parameter int         CELL_LEN  = 53,
  parameter int         HEC_POS   = 4,
  parameter logic [7:0] FILL_BYTE = 8'h6A,
  parameter logic [7:0] CRC_POLY  = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sop,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic [7:0] out_data,
  output logic       out_sop,
  output logic       out_idle
);
  localparam int PW = $clog2(CELL_LEN);

  logic [PW-1:0] pos;
  logic          at_start;
  src_e          src_q;
  src_e          src_cur;
  logic [7:0]    hec;
  logic [7:0]    nxt_byte;

  cell_slot_ctr #(.CELL_LEN(CELL_LEN), .PW(PW)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .pos      (pos),
    .at_start (at_start)
  );

  // The slot kind is chosen on byte 0 and held for the remaining bytes.
  always_comb begin
    if (at_start) begin
      src_cur = (in_valid && in_sop) ? SRC_USER : SRC_IDLE;
    end else begin
      src_cur = src_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= SRC_IDLE;
    end else if (at_start) begin
      src_q <= src_cur;
    end
  end

  assign in_ready = at_start || (src_q == SRC_USER);

  hec_acc #(.PW(PW), .HEC_POS(HEC_POS), .CRC_POLY(CRC_POLY)) u_hec (
    .clk     (clk),
    .rst_n   (rst_n),
    .pos     (pos),
    .byte_in (nxt_byte),
    .hec     (hec)
  );

  cell_byte_sel #(.PW(PW), .HEC_POS(HEC_POS), .FILL_BYTE(FILL_BYTE)) u_sel (
    .src      (src_cur),
    .pos      (pos),
    .in_valid (in_valid),
    .in_data  (in_data),
    .hec      (hec),
    .nxt_byte (nxt_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data <= 8'h00;
      out_sop  <= 1'b0;
      out_idle <= 1'b0;
    end else begin
      out_data <= nxt_byte;
      out_sop  <= at_start;
      out_idle <= (src_cur == SRC_IDLE);
    end
  end
endmodule

// File: rtl/cell_hec_tx_chk.sv
module cell_hec_tx_chk
  import cell_tx_pkg::*;
#(
  parameter int         CELL_LEN  = 53,
  parameter int         HEC_POS   = 4,
  parameter logic [7:0] FILL_BYTE = 8'h6A,
  parameter logic [7:0] CRC_POLY  = 8'h07
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic [7:0] out_data,
  input logic       out_sop,
  input logic       out_idle
);
  localparam int PW = $clog2(CELL_LEN);
  localparam logic [PW-1:0] HPOS = PW'(HEC_POS);
  localparam logic [PW-1:0] LAST = PW'(CELL_LEN - 1);

  logic          primed;
  logic [PW-1:0] cpos_q;
  logic [PW-1:0] cur;
  logic [7:0]    crc_q;

  assign cur = out_sop ? '0 : cpos_q;

  // Independent CRC over the output stream itself.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed <= 1'b0;
      cpos_q <= '0;
      crc_q  <= 8'h00;
    end else begin
      if (out_sop) primed <= 1'b1;
      cpos_q <= cur + 1'b1;
      if (out_sop) begin
        crc_q <= crc8_step(8'h00, out_data, CRC_POLY);
      end else if (cur < HPOS) begin
        crc_q <= crc8_step(crc_q, out_data, CRC_POLY);
      end
    end
  end

  assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && cur == LAST) |=> out_sop);
  assert_sop_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |=> !out_sop);
  assert_hec_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !out_sop && cur == HPOS) |-> (out_data == crc_q));
  assert_idle_hdr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && out_idle && cur <= HPOS) |-> (out_data == 8'h00));
  assert_idle_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && out_idle && cur > HPOS) |-> (out_data == FILL_BYTE));
  assert_idle_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !out_sop) |-> $stable(out_idle));
  assert_ready_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && out_idle && !out_sop) |-> !$past(in_ready));
endmodule

bind cell_hec_tx cell_hec_tx_chk #(
  .CELL_LEN(CELL_LEN), .HEC_POS(HEC_POS), .FILL_BYTE(FILL_BYTE), .CRC_POLY(CRC_POLY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .out_data(out_data), .out_sop(out_sop), .out_idle(out_idle)
);

// File: tb/sim_cell_hec_tx.sv
module sim_cell_hec_tx;
  localparam int CL = 53;
  localparam int NSLOT = 128;
  localparam int NC = NSLOT * CL + 8;
  localparam int K_IDLE = 0, K_USER = 1, K_STRAY = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_sop, out_idle;
  logic [7:0] out_data;

  always #2 clk = ~clk;

  cell_hec_tx u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_data(in_data), .in_ready(in_ready), .out_data(out_data),
    .out_sop(out_sop), .out_idle(out_idle)
  );

  int errors = 0, checks = 0, k = 0, nslot = 0;
  bit done = 0;
  logic [7:0] exp_d [0:NC-1];
  logic [7:0] act_d [0:NC-1];
  logic exp_s [0:NC-1];
  logic act_s [0:NC-1];
  logic exp_i [0:NC-1];
  logic act_i [0:NC-1];
  bit rdy_bad [0:NSLOT-1];
  string tag [0:NSLOT-1];

  function automatic logic [7:0] ref_hec(input logic [31:0] h);
    logic [39:0] v;
    v = {h, 8'h00};
    for (int i = 39; i >= 8; i--) begin
      if (v[i]) v[i -: 9] = v[i -: 9] ^ 9'h107;
    end
    return v[7:0];
  endfunction

  task automatic do_slot(input int kind, input logic [31:0] hdr, input int gap,
                         input int msop, input string t);
    logic [31:0] eh;
    eh = hdr;
    for (int b = 0; b < 4; b++) if (gap == b) eh[31-8*b -: 8] = 8'h6A;
    tag[nslot] = t;
    rdy_bad[nslot] = 0;
    for (int j = 0; j < CL; j++) begin
      logic v, s;
      logic [7:0] d, e;
      @(negedge clk);
      if (k > 0) begin
        act_d[k-1] = out_data; act_s[k-1] = out_sop; act_i[k-1] = out_idle;
      end
      if (in_ready !== ((j == 0) || (kind == K_USER))) rdy_bad[nslot] = 1;
      if (kind == K_USER) begin
        v = (j != gap);
        s = (j == 0) || (j == msop);
        if (j < 4) d = hdr[31-8*j -: 8];
        else if (j == 4) d = 8'hC3;
        else d = 8'((j * 37 + int'(hdr[7:0])) & 255);
        if (j == gap) e = 8'h6A;
        else if (j == 4) e = ref_hec(eh);
        else e = d;
      end else begin
        v = (kind == K_STRAY) && (j == 0);
        s = 1'b0;
        d = 8'h55;
        e = (j <= 4) ? 8'h00 : 8'h6A;
      end
      in_valid = v; in_sop = s; in_data = d;
      exp_d[k] = e; exp_s[k] = (j == 0); exp_i[k] = (kind != K_USER);
      k++;
    end
    nslot++;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    logic [31:0] h;
    repeat (3) @(negedge clk);
    checks++;
    if (out_data !== 8'h00 || out_sop !== 1'b0 || out_idle !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset state actual=%h/%b/%b/%b expected=00/0/0/1",
               out_data, out_sop, out_idle, in_ready);
    end
    @(posedge clk);
    #1 rst_n = 1'b1;

    do_slot(K_IDLE, 0, -1, -1, "R2 R4 R5 R7 idle");
    do_slot(K_STRAY, 0, -1, -1, "R8 stray byte");
    do_slot(K_IDLE, 0, -1, -1, "R4 R5 idle");
    for (int b = 0; b < 32; b++) do_slot(K_USER, 32'h1 << b, -1, -1, "R3 R6 one-hot header");
    h = 32'h1234_5678;
    for (int n = 0; n < 40; n++) begin
      h = h * 32'd1103515245 + 32'd12345;
      do_slot(K_USER, h, -1, -1, "R2 R3 R6 R7 random header");
      if (n % 8 == 7) do_slot(K_IDLE, 0, -1, -1, "R2 R4 R5 idle between cells");
    end
    do_slot(K_USER, 32'hDEAD_BEEF, 2, -1, "R9 header gap");
    do_slot(K_USER, 32'h0102_0304, 30, -1, "R9 payload gap");
    do_slot(K_USER, 32'hA5A5_0F0F, -1, 17, "R10 mid-cell sop");
    do_slot(K_USER, 32'hFFFF_FFFF, -1, -1, "R3 all-ones header");
    do_slot(K_STRAY, 0, -1, -1, "R8 stray byte");
    do_slot(K_IDLE, 0, -1, -1, "R4 R5 final idle");
    @(negedge clk);
    act_d[k-1] = out_data; act_s[k-1] = out_sop; act_i[k-1] = out_idle;

    for (int s = 0; s < nslot; s++) begin
      int bad;
      bad = -1;
      for (int j = CL - 1; j >= 0; j--) begin
        int x;
        x = s * CL + j;
        if (act_d[x] !== exp_d[x] || act_s[x] !== exp_s[x] || act_i[x] !== exp_i[x]) bad = j;
      end
      checks++;
      if (bad >= 0) begin
        errors++;
        $display("FAIL %s slot %0d byte %0d actual=%h/%b/%b expected=%h/%b/%b", tag[s], s, bad,
                 act_d[s*CL+bad], act_s[s*CL+bad], act_i[s*CL+bad],
                 exp_d[s*CL+bad], exp_s[s*CL+bad], exp_i[s*CL+bad]);
      end
      checks++;
      if (rdy_bad[s]) begin
        errors++;
        $display("FAIL R7 in_ready slot %0d (%s) actual=mismatch expected=ready pattern", s, tag[s]);
      end
    end
    summary();
    done = 1;
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule